// File: doc/BRIEF.md
# Branch Confidence Fetch Throttle

This block labels every decoded conditional branch as trusted or doubtful and holds back instruction fetch once too many doubtful branches are still waiting to resolve. Trust comes from a table of small saturating counters. Each counter records how many times in a row the branches that map to its entry were predicted correctly. A branch whose counter is above a fixed confidence limit is trusted. Any other branch is doubtful.

The table is addressed by mixing a slice of the branch address with a speculative global direction history, using XOR. The decode stage receives the doubtful bit and the table address. It keeps both with the branch and returns them when the branch resolves, together with a flag that says whether the prediction held. Resolution trains the addressed counter. A separate counter tracks how many doubtful branches are in flight. While that count is above a gating level set at run time, fetch is held. When the pipeline squashes branches, it tells the block how many doubtful ones were lost.

A build-time option picks the training rule for the counters. The default clears a counter on a misprediction. The other rule steps it down by one.

Top module: `fetch_gate_ctl`

## Requirements
- R1: After reset every table counter, the history register and the in-flight count are zero. So every decoded branch reads doubtful (`dec_low_conf`=1) and `fetch_gate` is 0 for any `gate_n`.
- R2: `dec_idx` equals `dec_pc[PC_LSB+IDX_W-1:PC_LSB]` XOR the history register. Each cycle with `dec_valid`=1, the history shifts left by one and `dec_taken` enters bit 0.
- R3: `dec_low_conf` is 1 when the counter at `dec_idx` is less than or equal to `CONF_THR`, and 0 when it is greater. A training write in the same cycle is not visible to that read.
- R4: In the default up/reset mode, a resolve with `res_correct`=1 increments the counter at `res_idx`, saturating at 2^CNT_W-1. A resolve with `res_correct`=0 clears that counter to zero.
- R5: In the up/down mode, a correct resolve increments the counter with saturation at 2^CNT_W-1. A misprediction decrements it with saturation at zero.
- R6: A doubtful decode (`dec_valid`=1 and `dec_low_conf`=1) adds one to the in-flight count. A resolve with `res_valid`=1 and `res_low_conf`=1 removes one. When both happen in the same cycle, the count is unchanged.
- R7: The in-flight count never goes below zero and never goes above 2^INF_W-1. An update that would leave that range is clamped to its nearest end.
- R8: A cycle with `flush_valid`=1 subtracts `flush_cnt` from the in-flight count, in the same update as R6, with the result clamped to zero.
- R9: `fetch_gate` is 1 exactly when the registered in-flight count is greater than `gate_n`. It changes in the cycle after the update that moves the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | A conditional branch is decoded this cycle |
| dec_pc | input | PC_W | Address of the decoded branch |
| dec_taken | input | 1 | Predicted direction, shifted into the history |
| dec_low_conf | output | 1 | Doubtful label for the decoded branch |
| dec_idx | output | IDX_W | Table address to keep with the branch |
| res_valid | input | 1 | A branch resolves this cycle |
| res_idx | input | IDX_W | Table address kept at decode |
| res_low_conf | input | 1 | Doubtful label kept at decode |
| res_correct | input | 1 | The prediction for the branch was right |
| flush_valid | input | 1 | Squash of speculative branches |
| flush_cnt | input | INF_W | Number of doubtful branches squashed |
| gate_n | input | INF_W | Gating level for the in-flight count |
| fetch_gate | output | 1 | Hold fetch |

## Verification
A wrong counter in the table shows up only on a later decode that reads the same entry, which then returns a flipped `dec_low_conf`. That can happen many cycles after the bad training write, so a behavioural model of every entry is compared on each cycle. A wrong in-flight count is hidden until it crosses `gate_n`. For that reason the bench sweeps the gating level and also drives the count hard against both of its saturation ends. A history that is off by one bit corrupts `dec_idx` on the very next decode.

// File: rtl/fgc_pkg.sv
package fgc_pkg;
   typedef enum logic {
      CNT_UP_RESET = 1'b0,
      CNT_UP_DOWN  = 1'b1
   } cnt_mode_e;
endpackage

// File: rtl/fgc_hist.sv
module fgc_hist #(
   parameter int IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_en,
   input  logic             bit_in,
   output logic [IDX_W-1:0] hist
);
   generate
      if (IDX_W < 2) begin : g_bad
         $error("fgc_hist: IDX_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)        hist <= '0;
      else if (shift_en) hist <= {hist[IDX_W-2:0], bit_in};
   end

   AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> hist[0] == $past(bit_in)) else $error("history shift");   // R2
endmodule

// File: rtl/fgc_conf_table.sv
module fgc_conf_table
   import fgc_pkg::*;
#(
   parameter int        IDX_W    = 6,
   parameter int        CNT_W    = 3,
   parameter int        CONF_THR = 3,
   parameter cnt_mode_e MODE     = CNT_UP_RESET
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_low,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_ok
);
   localparam int            DEPTH = 1 << IDX_W;
   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] THR  = CNT_W'(CONF_THR);

   generate
      if (CONF_THR < 0 || CONF_THR >= (1 << CNT_W) - 1) begin : g_bad_thr
         $error("fgc_conf_table: CONF_THR out of counter range");
      end
      if (IDX_W > 12) begin : g_bad_idx
         $error("fgc_conf_table: table too deep");
      end
   endgenerate

   logic [CNT_W-1:0] tbl [DEPTH];
   logic [CNT_W-1:0] cur, nxt;

   assign cur    = tbl[wr_idx];
   assign rd_low = (tbl[rd_idx] <= THR);

   generate
      if (MODE == CNT_UP_RESET) begin : g_upreset
         always_comb begin
            if (wr_ok) nxt = (cur == CMAX) ? CMAX : cur + ONE;
            else       nxt = '0;
         end
         AST_MISS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en && !wr_ok |=> tbl[$past(wr_idx)] == '0) else $error("miss clear");   // R4
      end else begin : g_updown
         always_comb begin
            if (wr_ok) nxt = (cur == CMAX) ? CMAX : cur + ONE;
            else       nxt = (cur == '0) ? '0 : cur - ONE;
         end
         AST_MISS_STEPS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en && !wr_ok && (cur != '0) |=> tbl[$past(wr_idx)] == $past(cur) - ONE)
            else $error("miss step");   // R5
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
      end else if (wr_en) begin
         tbl[wr_idx] <= nxt;
      end
   end

   AST_HIT_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_ok |=> tbl[$past(wr_idx)] >= $past(cur)) else $error("hit drop");   // R4
endmodule

// File: rtl/fgc_inflight.sv
module fgc_inflight #(
   parameter int INF_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             dec,
   input  logic             sub_en,
   input  logic [INF_W-1:0] sub_cnt,
   input  logic [INF_W-1:0] thresh,
   output logic [INF_W-1:0] count,
   output logic             over
);
   localparam int SUM_W = INF_W + 2;
   localparam logic signed [SUM_W-1:0] SMAX = SUM_W'((1 << INF_W) - 1);

   generate
      if (INF_W < 1 || INF_W > 16) begin : g_bad
         $error("fgc_inflight: INF_W out of range");
      end
   endgenerate

   logic signed [SUM_W-1:0] sum;
   logic [INF_W-1:0]        nxt;

   always_comb begin
      sum = $signed({2'b00, count})
          + $signed(SUM_W'(inc))
          - $signed(SUM_W'(dec))
          - (sub_en ? $signed({2'b00, sub_cnt}) : '0);
      if (sum < 0)         nxt = '0;
      else if (sum > SMAX) nxt = {INF_W{1'b1}};
      else                 nxt = sum[INF_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) count <= '0;
      else        count <= nxt;
   end

   assign over = (count > thresh);

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (&count) && inc && !dec && !sub_en |=> (&count)) else $error("overflow");   // R7
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0) && !inc |=> (count == '0)) else $error("underflow");   // R7
   AST_BALANCED: assert property (@(posedge clk) disable iff (!rst_n)
      inc && dec && !sub_en |=> $stable(count)) else $error("balance");   // R6
   AST_FLUSH_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
      sub_en && !inc |=> count <= $past(count)) else $error("flush grow");   // R8
endmodule

// File: rtl/fetch_gate_ctl.sv
module fetch_gate_ctl
   import fgc_pkg::*;
#(
   parameter int        PC_W     = 32,
   parameter int        PC_LSB   = 2,
   parameter int        IDX_W    = 6,
   parameter int        CNT_W    = 3,
   parameter int        CONF_THR = 3,
   parameter int        INF_W    = 4,
   parameter cnt_mode_e MODE     = CNT_UP_RESET
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dec_valid,
   input  logic [PC_W-1:0]  dec_pc,
   input  logic             dec_taken,
   output logic             dec_low_conf,
   output logic [IDX_W-1:0] dec_idx,
   input  logic             res_valid,
   input  logic [IDX_W-1:0] res_idx,
   input  logic             res_low_conf,
   input  logic             res_correct,
   input  logic             flush_valid,
   input  logic [INF_W-1:0] flush_cnt,
   input  logic [INF_W-1:0] gate_n,
   output logic             fetch_gate
);
   generate
      if (PC_LSB + IDX_W > PC_W) begin : g_bad_pc
         $error("fetch_gate_ctl: index slice exceeds PC width");
      end
   endgenerate

   logic [IDX_W-1:0] ghr;
   logic [INF_W-1:0] inflight;
   logic             unused_pc;

   assign unused_pc = ^dec_pc;
   assign dec_idx   = dec_pc[PC_LSB +: IDX_W] ^ ghr;

   fgc_hist #(.IDX_W(IDX_W)) u_hist (
      .clk(clk), .rst_n(rst_n), .shift_en(dec_valid), .bit_in(dec_taken), .hist(ghr)
   );

   fgc_conf_table #(.IDX_W(IDX_W), .CNT_W(CNT_W), .CONF_THR(CONF_THR), .MODE(MODE)) u_tbl (
      .clk(clk), .rst_n(rst_n), .rd_idx(dec_idx), .rd_low(dec_low_conf),
      .wr_en(res_valid), .wr_idx(res_idx), .wr_ok(res_correct)
   );

   fgc_inflight #(.INF_W(INF_W)) u_inf (
      .clk(clk), .rst_n(rst_n),
      .inc(dec_valid && dec_low_conf),
      .dec(res_valid && res_low_conf),
      .sub_en(flush_valid), .sub_cnt(flush_cnt),
      .thresh(gate_n), .count(inflight), .over(fetch_gate)
   );

   AST_GATE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (inflight == '0) |-> !fetch_gate) else $error("gate idle");   // R9
endmodule

// File: tb/sim_fetch_gate_ctl.sv
module sim_fetch_gate_ctl;
   localparam int CLK_PERIOD = 10;
   localparam int IDX_W = 6, INF_W = 4, CNT_MAX = 7, THR = 3, INF_MAX = 15;

   logic clk = 0, rst_n = 0;
   logic dec_valid = 0, dec_taken = 0, res_valid = 0, res_low_conf = 0, res_correct = 0;
   logic flush_valid = 0;
   logic [31:0] dec_pc = 0;
   logic [IDX_W-1:0] res_idx = 0;
   logic [INF_W-1:0] flush_cnt = 0, gate_n = 0;
   logic low0, low1, gate0, gate1;
   logic [IDX_W-1:0] idx0, idx1;

   int tbl [2][64];
   int ghr;
   int inf [2];
   int vectors = 0, misses = 0;
   string ph = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   fetch_gate_ctl u0 (
      .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_pc(dec_pc), .dec_taken(dec_taken),
      .dec_low_conf(low0), .dec_idx(idx0), .res_valid(res_valid), .res_idx(res_idx),
      .res_low_conf(res_low_conf), .res_correct(res_correct), .flush_valid(flush_valid),
      .flush_cnt(flush_cnt), .gate_n(gate_n), .fetch_gate(gate0));

   fetch_gate_ctl #(.MODE(fgc_pkg::CNT_UP_DOWN)) u1 (
      .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_pc(dec_pc), .dec_taken(dec_taken),
      .dec_low_conf(low1), .dec_idx(idx1), .res_valid(res_valid), .res_idx(res_idx),
      .res_low_conf(res_low_conf), .res_correct(res_correct), .flush_valid(flush_valid),
      .flush_cnt(flush_cnt), .gate_n(gate_n), .fetch_gate(gate1));

   task automatic cmp(string tag, string what, int k, int got, int exp);
      vectors++;
      if (got != exp) begin
         misses++;
         $display("FAIL %s %s inst%0d: got %0d expected %0d", tag, what, k, got, exp);
      end
   endtask

   function automatic int exp_idx();
      return ((dec_pc >> 2) & 63) ^ ghr;
   endfunction

   task automatic step();
      int ix, low [2];
      #1;
      ix = exp_idx();
      for (int k = 0; k < 2; k++) low[k] = (tbl[k][ix] <= THR) ? 1 : 0;
      cmp("R2", "dec_idx", 0, idx0, ix);
      cmp("R2", "dec_idx", 1, idx1, ix);
      cmp({ph, " R3 R4"}, "dec_low_conf", 0, low0, low[0]);
      cmp({ph, " R3 R5"}, "dec_low_conf", 1, low1, low[1]);
      cmp({ph, " R9"}, "fetch_gate", 0, gate0, (inf[0] > gate_n) ? 1 : 0);
      cmp({ph, " R9"}, "fetch_gate", 1, gate1, (inf[1] > gate_n) ? 1 : 0);
      @(posedge clk);
      for (int k = 0; k < 2; k++) begin
         int s;
         s = inf[k] + ((dec_valid && low[k]) ? 1 : 0) - ((res_valid && res_low_conf) ? 1 : 0)
             - (flush_valid ? int'(flush_cnt) : 0);
         inf[k] = (s < 0) ? 0 : (s > INF_MAX) ? INF_MAX : s;
         if (res_valid) begin
            int c;
            c = tbl[k][res_idx];
            if (res_correct) c = (c == CNT_MAX) ? CNT_MAX : c + 1;
            else if (k == 0) c = 0;
            else c = (c == 0) ? 0 : c - 1;
            tbl[k][res_idx] = c;
         end
      end
      if (dec_valid) ghr = ((ghr << 1) | int'(dec_taken)) & 63;
      @(negedge clk);
   endtask

   task automatic idle();
      dec_valid = 0; res_valid = 0; flush_valid = 0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      misses++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      for (int k = 0; k < 2; k++) begin
         inf[k] = 0;
         for (int i = 0; i < 64; i++) tbl[k][i] = 0;
      end
      ghr = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: reset state
      ph = "R1";
      for (int i = 0; i < 4; i++) begin dec_pc = $urandom; gate_n = 4'(i); step(); end
      // R6: single doubtful decode, balanced cycle, resolve
      ph = "R6"; gate_n = 0;
      dec_valid = 1; dec_pc = $urandom; step();
      res_valid = 1; res_low_conf = 1; res_correct = 1; res_idx = 5; dec_pc = $urandom; step();
      dec_valid = 0; step();
      idle(); step();
      // R7: drive into top and bottom saturation
      ph = "R7"; gate_n = 14;
      for (int i = 0; i < 20; i++) begin dec_valid = 1; dec_pc = 32'(i * 4096); dec_taken = 0; step(); end
      idle(); step();
      res_valid = 1; res_low_conf = 1; res_correct = 0; res_idx = 9; step();
      idle(); step();
      gate_n = 0;
      for (int i = 0; i < 18; i++) begin res_valid = 1; res_low_conf = 1; step(); end
      idle(); dec_valid = 1; step();
      idle(); step();
      // R8: flush subtraction and clamp
      ph = "R8"; gate_n = 3;
      for (int i = 0; i < 10; i++) begin dec_valid = 1; dec_pc = $urandom; step(); end
      idle(); flush_valid = 1; flush_cnt = 4; step();
      idle(); step();
      flush_valid = 1; flush_cnt = 15; dec_valid = 1; step();
      idle(); step();
      // R4 R5: training with mostly correct outcomes
      ph = "R4 R5";
      for (int i = 0; i < 4000; i++) begin
         dec_valid = ($urandom % 3) != 0; dec_pc = $urandom; dec_taken = $urandom;
         res_valid = ($urandom % 4) != 0; res_idx = IDX_W'($urandom);
         res_low_conf = $urandom; res_correct = ($urandom % 8) != 0;
         flush_valid = ($urandom % 64) == 0; flush_cnt = INF_W'($urandom);
         gate_n = INF_W'($urandom % 6);
         step();
      end
      // R9: random mix with a swept gating level
      ph = "R9";
      for (int i = 0; i < 4000; i++) begin
         dec_valid = $urandom; dec_pc = $urandom & 32'hff; dec_taken = $urandom;
         res_valid = $urandom; res_idx = IDX_W'($urandom);
         res_low_conf = ($urandom % 3) == 0; res_correct = ($urandom % 3) != 0;
         flush_valid = ($urandom % 100) == 0; flush_cnt = INF_W'($urandom % 4);
         gate_n = INF_W'(i / 250);
         step();
      end
      idle(); step();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule